// File: doc/BRIEF.md
# Eager-Forward Route Checker

This block sits at one input of a mesh switch whose outputs are tied to preferred inputs, so that a flit can be pushed on to the next switch before anyone has looked at its header. On arrival, the block compares the flit's destination coordinates with the coordinates of this switch. It decides whether the speculative hop the flit just took was worth taking. If it was not, the flit is dead and is dropped at the end of its preferred path. The block also decides whether the flit must be written into the local input FIFO, and it gives the output port that dimension-ordered (X first, then Y) routing would pick.

The progress rule is relaxed compared with strict XY routing. A speculative hop is good if it shortens the distance to the destination in at least one axis, even if XY routing would have taken the other axis first. The decision is purely combinational and is valid in the cycle the flit is presented. Flits that are not on a preferred path always go through the FIFO. A live speculative flit is also written into the FIFO in three cases: the next hop signals almost-full, its onward preferred hop would not make progress, or it has reached its destination. A live speculative flit that is also queued can therefore leave the switch as two copies.

Port directions are coded 0 = local, 1 = east (X + 1), 2 = west (X − 1), 3 = north (Y + 1), 4 = south (Y − 1). Codes 5 to 7 behave like local. Coordinates are unsigned.

Top module: `eager_route_check`

## Requirements
- R1: `route_port` gives the XY choice: east (1) if dst_x > loc_x, west (2) if dst_x < loc_x, otherwise north (3) if dst_y > loc_y, south (4) if dst_y < loc_y, and local (0) when both coordinates match.
- R2: A valid flit with `on_pref`=1 that entered through a cardinal port (codes 1 to 4), whose sender lies in that direction, and whose sender was at least as close in both axes as this switch, raises `dead` and clears `fwd_ok`.
- R3: A valid `on_pref` flit whose incoming hop shortened the distance in at least one axis raises `fwd_ok` and keeps `dead` low. This holds even when X still differs and the hop was along Y.
- R4: A valid flit whose destination equals the local coordinates is never dead. It is always queued (`enq`=1) and gets `route_port`=0.
- R5: A valid flit with `on_pref`=0 is always queued, with `dead`=0 and `fwd_ok`=0.
- R6: A live `on_pref` flit is queued whenever `nxt_afull`=1.
- R7: A live `on_pref` flit that is not at its destination is queued when the neighbour in direction `pref_port` is no closer than this switch in either axis. It is not queued when that neighbour is closer and `nxt_afull`=0.
- R8: A dead flit is never queued, even with `nxt_afull`=1.
- R9: With `flit_vld`=0, `enq`, `dead` and `fwd_ok` are all 0.
- R10: An `on_pref` flit entering through the local port (code 0) has made no hop and is treated as live.
- R11: An onward preferred hop that leaves the mesh edge (for example, west from X = 0) counts as no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flit_vld | input | 1 | A flit header is presented this cycle |
| on_pref | input | 1 | The flit arrived over a preferred path (eagerly forwarded) |
| arr_port | input | 3 | Port code through which the flit entered |
| pref_port | input | 3 | Port code of the output this input is preferred-tied to |
| nxt_afull | input | 1 | Almost-full indication from the hop after the preferred output |
| loc_x | input | X_W | X coordinate of this switch |
| loc_y | input | Y_W | Y coordinate of this switch |
| dst_x | input | X_W | Destination X from the flit header |
| dst_y | input | Y_W | Destination Y from the flit header |
| fwd_ok | output | 1 | The eager hop into this switch was useful (flit live) |
| dead | output | 1 | Flit is dead; drop at end of preferred path |
| enq | output | 1 | Write the flit into the local input FIFO |
| route_port | output | 3 | XY output port code for the queued copy |

## Verification
The XY selector is driven with destinations to the east, west, north and south of a central switch, and with one equal to the switch itself. This tells apart the X-before-Y priority and the local ejection case. The live/dead rule is tried with a backward hop along X, a forward hop along Y that is off the XY route, a hop landing exactly on the destination, and a local injection. These separate the relaxed rule from strict XY routing and from the at-destination exemption. The queueing decision is exercised with onward hops that progress, regress, or fall off the mesh edge, each with and without almost-full. A dead flit under almost-full shows that dropping takes priority over queueing.

// File: rtl/rtchk_pkg.sv
package rtchk_pkg;
   localparam int PORT_W = 3;

   typedef enum logic [PORT_W-1:0] {
      PORT_LOCAL = 3'd0,
      PORT_EAST  = 3'd1,
      PORT_WEST  = 3'd2,
      PORT_NORTH = 3'd3,
      PORT_SOUTH = 3'd4
   } port_e;

   function automatic logic port_is_cardinal(input logic [PORT_W-1:0] p);
      return (p == PORT_EAST) || (p == PORT_WEST) ||
             (p == PORT_NORTH) || (p == PORT_SOUTH);
   endfunction
endpackage

// File: rtl/rtchk_hop_eval.sv
// Compares the distance-to-destination of this switch with that of its
// neighbour in direction dir, per axis, using widened signed coordinates
// so that a neighbour beyond the mesh edge is represented exactly.
module rtchk_hop_eval
   import rtchk_pkg::*;
#(
   parameter int X_W = 4,
   parameter int Y_W = 4
) (
   input  logic [X_W-1:0]    loc_x,
   input  logic [Y_W-1:0]    loc_y,
   input  logic [X_W-1:0]    dst_x,
   input  logic [Y_W-1:0]    dst_y,
   input  logic [PORT_W-1:0] dir,
   output logic              nb_closer,
   output logic              loc_closer
);
   localparam int XE = X_W + 2;
   localparam int YE = Y_W + 2;
   localparam logic [XE-1:0] X_ONE = {{(XE-1){1'b0}}, 1'b1};
   localparam logic [YE-1:0] Y_ONE = {{(YE-1){1'b0}}, 1'b1};

   logic signed [XE-1:0] lx, nx, tx, dlx, dnx;
   logic signed [YE-1:0] ly, ny, ty, dly, dny;

   always_comb begin
      lx = {2'b00, loc_x};
      ly = {2'b00, loc_y};
      tx = {2'b00, dst_x};
      ty = {2'b00, dst_y};
      nx = lx;
      ny = ly;
      case (dir)
         PORT_EAST:  nx = lx + X_ONE;
         PORT_WEST:  nx = lx - X_ONE;
         PORT_NORTH: ny = ly + Y_ONE;
         PORT_SOUTH: ny = ly - Y_ONE;
         default: ;
      endcase
      dlx = (tx >= lx) ? (tx - lx) : (lx - tx);
      dnx = (tx >= nx) ? (tx - nx) : (nx - tx);
      dly = (ty >= ly) ? (ty - ly) : (ly - ty);
      dny = (ty >= ny) ? (ty - ny) : (ny - ty);
      nb_closer  = (dnx < dlx) || (dny < dly);
      loc_closer = (dlx < dnx) || (dly < dny);
   end
endmodule

// File: rtl/rtchk_xy_sel.sv
// Dimension-ordered output choice: resolve X first, then Y, then eject.
module rtchk_xy_sel
   import rtchk_pkg::*;
#(
   parameter int X_W = 4,
   parameter int Y_W = 4
) (
   input  logic [X_W-1:0]    loc_x,
   input  logic [Y_W-1:0]    loc_y,
   input  logic [X_W-1:0]    dst_x,
   input  logic [Y_W-1:0]    dst_y,
   output logic [PORT_W-1:0] port
);
   always_comb begin
      if (dst_x > loc_x)      port = PORT_EAST;
      else if (dst_x < loc_x) port = PORT_WEST;
      else if (dst_y > loc_y) port = PORT_NORTH;
      else if (dst_y < loc_y) port = PORT_SOUTH;
      else                    port = PORT_LOCAL;
   end
endmodule

// File: rtl/eager_route_check.sv
module eager_route_check
   import rtchk_pkg::*;
#(
   parameter int X_W = 4,
   parameter int Y_W = 4
) (
   input  logic           flit_vld,
   input  logic           on_pref,
   input  logic [2:0]     arr_port,
   input  logic [2:0]     pref_port,
   input  logic           nxt_afull,
   input  logic [X_W-1:0] loc_x,
   input  logic [Y_W-1:0] loc_y,
   input  logic [X_W-1:0] dst_x,
   input  logic [Y_W-1:0] dst_y,
   output logic           fwd_ok,
   output logic           dead,
   output logic           enq,
   output logic [2:0]     route_port
);
   localparam int N_HOP   = 2;   // 0: hop into this switch, 1: onward hop
   localparam int HOP_IN  = 0;
   localparam int HOP_OUT = 1;

   if (X_W < 1 || Y_W < 1) begin : g_bad_width
      $error("eager_route_check: coordinate widths must be at least 1");
   end
   if (PORT_W != 3) begin : g_bad_port
      $error("eager_route_check: port code width must be 3");
   end

   logic [PORT_W-1:0] hop_dir    [N_HOP];
   logic              nb_cl      [N_HOP];
   logic              loc_cl     [N_HOP];

   assign hop_dir[HOP_IN]  = arr_port;
   assign hop_dir[HOP_OUT] = pref_port;

   for (genvar i = 0; i < N_HOP; i++) begin : g_hop
      rtchk_hop_eval #(.X_W(X_W), .Y_W(Y_W)) u_hop (
         .loc_x      (loc_x),
         .loc_y      (loc_y),
         .dst_x      (dst_x),
         .dst_y      (dst_y),
         .dir        (hop_dir[i]),
         .nb_closer  (nb_cl[i]),
         .loc_closer (loc_cl[i])
      );
   end

   rtchk_xy_sel #(.X_W(X_W), .Y_W(Y_W)) u_xy (
      .loc_x (loc_x),
      .loc_y (loc_y),
      .dst_x (dst_x),
      .dst_y (dst_y),
      .port  (route_port)
   );

   logic at_dest;
   logic in_live;
   logic out_useful;

   always_comb begin
      at_dest    = (dst_x == loc_x) && (dst_y == loc_y);
      // Incoming hop came from the neighbour in direction arr_port; it was
      // useful if this switch is closer than that sender in some axis.
      in_live    = !port_is_cardinal(arr_port) || loc_cl[HOP_IN] || at_dest;
      out_useful = nb_cl[HOP_OUT];
      fwd_ok     = flit_vld && on_pref && in_live;
      dead       = flit_vld && on_pref && !in_live;
      enq        = flit_vld && (!on_pref || at_dest ||
                                (in_live && (nxt_afull || !out_useful)));
   end
endmodule

// File: rtl/rtchk_props.sv
module rtchk_props #(
   parameter int X_W = 4,
   parameter int Y_W = 4
) (
   input logic           flit_vld,
   input logic           on_pref,
   input logic           nxt_afull,
   input logic [X_W-1:0] loc_x,
   input logic [Y_W-1:0] loc_y,
   input logic [X_W-1:0] dst_x,
   input logic [Y_W-1:0] dst_y,
   input logic           fwd_ok,
   input logic           dead,
   input logic           enq,
   input logic [2:0]     route_port
);
   always_comb begin
      AST_DEAD_LIVE_EXCL: assert (!(dead && fwd_ok)); // R2
      if (dead) begin
         AST_DEAD_NOT_QUEUED: assert (!enq); // R8
      end
      if (!flit_vld) begin
         AST_IDLE_QUIET: assert (!enq && !dead && !fwd_ok); // R9
      end
      if (flit_vld && dst_x == loc_x && dst_y == loc_y) begin
         AST_DEST_EJECT: assert (enq && !dead && route_port == 3'd0); // R4
      end
      if (flit_vld && !on_pref) begin
         AST_PLAIN_QUEUED: assert (enq && !dead && !fwd_ok); // R5
      end
      if (fwd_ok && nxt_afull) begin
         AST_AFULL_QUEUED: assert (enq); // R6
      end
      if (dst_x != loc_x) begin
         AST_X_FIRST: assert (route_port == 3'd1 || route_port == 3'd2); // R1
      end
   end
endmodule

bind eager_route_check rtchk_props #(.X_W(X_W), .Y_W(Y_W)) u_props (
   .flit_vld   (flit_vld),
   .on_pref    (on_pref),
   .nxt_afull  (nxt_afull),
   .loc_x      (loc_x),
   .loc_y      (loc_y),
   .dst_x      (dst_x),
   .dst_y      (dst_y),
   .fwd_ok     (fwd_ok),
   .dead       (dead),
   .enq        (enq),
   .route_port (route_port)
);

// File: tb/tb_eager_route_check.sv
module tb_eager_route_check;
   localparam int XW = 4;
   localparam int YW = 4;
   localparam logic [2:0] P_L = 3'd0, P_E = 3'd1, P_W = 3'd2, P_N = 3'd3, P_S = 3'd4;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          flit_vld, on_pref, nxt_afull;
   logic [2:0]    arr_port, pref_port;
   logic [XW-1:0] loc_x, dst_x;
   logic [YW-1:0] loc_y, dst_y;
   logic          fwd_ok, dead, enq;
   logic [2:0]    route_port;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   eager_route_check #(.X_W(XW), .Y_W(YW)) dut (
      .flit_vld(flit_vld), .on_pref(on_pref), .arr_port(arr_port),
      .pref_port(pref_port), .nxt_afull(nxt_afull),
      .loc_x(loc_x), .loc_y(loc_y), .dst_x(dst_x), .dst_y(dst_y),
      .fwd_ok(fwd_ok), .dead(dead), .enq(enq), .route_port(route_port)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic drive(input logic v, input logic p, input logic [2:0] ap,
                        input logic [2:0] pp, input logic af,
                        input int lx, input int ly, input int dx, input int dy);
      @(negedge clk);
      flit_vld = v; on_pref = p; arr_port = ap; pref_port = pp; nxt_afull = af;
      loc_x = XW'(lx); loc_y = YW'(ly); dst_x = XW'(dx); dst_y = YW'(dy);
      #1;
   endtask

   task automatic t_idle;
      drive(1'b0, 1'b1, P_E, P_N, 1'b1, 5, 5, 8, 5);
      chk("R9 idle enq", enq, 0);
      chk("R9 idle dead", dead, 0);
      chk("R9 idle fwd_ok", fwd_ok, 0);
   endtask

   task automatic t_xy;
      drive(1'b1, 1'b0, P_W, P_E, 1'b0, 5, 5, 7, 2);
      chk("R1 east", route_port, P_E);
      chk("R5 plain enq", enq, 1);
      chk("R5 plain dead", dead, 0);
      chk("R5 plain fwd_ok", fwd_ok, 0);
      drive(1'b1, 1'b0, P_W, P_E, 1'b0, 5, 5, 3, 9);
      chk("R1 west", route_port, P_W);
      drive(1'b1, 1'b0, P_W, P_E, 1'b0, 5, 5, 5, 9);
      chk("R1 north", route_port, P_N);
      drive(1'b1, 1'b0, P_W, P_E, 1'b0, 5, 5, 5, 1);
      chk("R1 south", route_port, P_S);
      drive(1'b1, 1'b0, P_W, P_E, 1'b0, 5, 5, 5, 5);
      chk("R1 local", route_port, P_L);
   endtask

   task automatic t_dead;
      // Entered from the east neighbour (6,5), destination (8,5): moved away.
      drive(1'b1, 1'b1, P_E, P_W, 1'b1, 5, 5, 8, 5);
      chk("R2 dead", dead, 1);
      chk("R2 fwd_ok low", fwd_ok, 0);
      chk("R8 dead not queued under afull", enq, 0);
   endtask

   task automatic t_live;
      // Entered from south neighbour (5,4) toward (2,9): Y shrank, X untouched.
      drive(1'b1, 1'b1, P_S, P_N, 1'b0, 5, 5, 2, 9);
      chk("R3 relaxed live fwd_ok", fwd_ok, 1);
      chk("R3 relaxed live dead", dead, 0);
      chk("R7 onward progress not queued", enq, 0);
      drive(1'b1, 1'b1, P_S, P_N, 1'b1, 5, 5, 2, 9);
      chk("R6 afull queued", enq, 1);
      drive(1'b1, 1'b1, P_S, P_E, 1'b0, 5, 5, 2, 9);
      chk("R7 onward regress queued", enq, 1);
   endtask

   task automatic t_dest;
      drive(1'b1, 1'b1, P_E, P_W, 1'b0, 5, 5, 5, 5);
      chk("R4 dest dead", dead, 0);
      chk("R4 dest enq", enq, 1);
      chk("R4 dest port", route_port, P_L);
   endtask

   task automatic t_inject;
      drive(1'b1, 1'b1, P_L, P_E, 1'b0, 5, 5, 9, 9);
      chk("R10 inject live", fwd_ok, 1);
      chk("R10 inject dead", dead, 0);
      chk("R10 inject not queued", enq, 0);
   endtask

   task automatic t_edge;
      // At X=0, entered from east (1,3) toward (0,7); onward west leaves mesh.
      drive(1'b1, 1'b1, P_E, P_W, 1'b0, 0, 3, 0, 7);
      chk("R11 edge live", fwd_ok, 1);
      chk("R11 off-mesh onward queued", enq, 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      flit_vld = 1'b0; on_pref = 1'b0; nxt_afull = 1'b0;
      arr_port = P_L; pref_port = P_L;
      loc_x = '0; loc_y = '0; dst_x = '0; dst_y = '0;
      repeat (2) @(posedge clk);
      t_idle();
      t_xy();
      t_dead();
      t_live();
      t_dest();
      t_inject();
      t_edge();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule